// File: doc/BRIEF.md
# Legacy Region Attribute Router

The router classifies each memory access that falls in the low legacy window (640 KB up to 1 MB) or in one of two optional fixed holes. Each access goes either to DRAM or to the memory-mapped I/O bus. Seven attribute bytes hold a 2-bit policy for each shadowable region. Bit 0 of a policy sends reads to DRAM and bit 1 sends writes to DRAM, so a region can, for example, read from DRAM while its writes go to I/O. The 128 KB display window at 0xA0000–0xBFFFF always goes to I/O. A 2-bit hole selector can open either the 512–640 KB hole or the 15–16 MB hole, and each of these then goes to I/O. Every other address goes to DRAM.

On each cycle the block samples the address, the write flag, the attribute bytes and the hole selector together with the valid strobe. It gives its answer in the next cycle as one of two flags. The answer is held in a three-state route register:

- `RT_IDLE`: no access was offered.
- `RT_DRAM`: the last access goes to DRAM.
- `RT_MMIO`: the last access goes to I/O.

The transitions do not depend on the current state. From any state, an absent strobe leads to `RT_IDLE`. A strobe leads to `RT_DRAM` when the decoded policy allows DRAM for that direction, and to `RT_MMIO` otherwise.

Top module: `legacy_route_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `to_dram` and `to_mmio` are low.
- R2: In the cycle after `acc_valid` is high, exactly one of `to_dram` and `to_mmio` is high. In the cycle after `acc_valid` is low, both are low.
- R3: The twelve 16 KB segments from 0xC0000 to 0xEFFFF take their policy from attribute bytes 1 to 6. Byte 1 + n/2 holds segment n, where segment n starts at 0xC0000 + n·0x4000. Bits [1:0] hold the even segment and bits [5:4] hold the odd one. Policy bit 0 set sends reads to DRAM and policy bit 1 set sends writes to DRAM; a clear bit sends that direction to I/O.
- R4: The 64 KB block 0xF0000–0xFFFFF takes its policy from bits [5:4] of attribute byte 0. The other bits of byte 0, and bits [3:2] and [7:6] of every byte, have no effect on routing.
- R5: Accesses to 0xA0000–0xBFFFF always go to I/O, whatever the attributes, the hole selector and the direction.
- R6: With `hole_sel` = 01, accesses to 0x80000–0x9FFFF go to I/O.
- R7: With `hole_sel` = 10, accesses to 0xF00000–0xFFFFFF go to I/O.
- R8: With `hole_sel` = 00 or 11, both hole ranges go to DRAM.
- R9: Any address not covered by R3–R7 goes to DRAM for reads and writes, and this includes addresses at or above 16 MB whose low 24 bits alias a legacy range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| attr_cfg | input | NUM_ATTR·ATTR_W (56) | Attribute bytes; byte k at bits [8k+7:8k] |
| hole_sel | input | 2 | Fixed-hole selector |
| to_dram | output | 1 | Registered: previous access goes to DRAM |
| to_mmio | output | 1 | Registered: previous access goes to I/O |

## Verification
The hardest cases to reach are the segment pairings. Here an odd and an even segment share one byte, yet each must take only its own field, in both directions, while the unused bits of the same byte toggle. The stimulus walks every segment with reads and writes under four rotating policy patterns, with the unused bits alternately set and cleared. A wiring slip between neighbouring fields therefore changes at least one answer. The holes are swept across all four selector codes, at their edges and at aliases above 16 MB.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
    typedef enum logic [1:0] {
        RT_IDLE = 2'b00,
        RT_DRAM = 2'b01,
        RT_MMIO = 2'b10
    } route_state_e;

    typedef enum logic [1:0] {
        HOLE_NONE = 2'b00,
        HOLE_LOW  = 2'b01,
        HOLE_HIGH = 2'b10,
        HOLE_RSVD = 2'b11
    } hole_code_e;

    localparam int SEG_SHIFT  = 14;   // 16 KB shadow segment
    localparam int MEG_SHIFT  = 20;   // 1 MB boundary
    localparam int HI_SHIFT   = 24;   // 16 MB boundary
    localparam int FIELD_W    = 2;
    localparam int HI_FIELD_L = 4;    // upper field starts at bit 4
endpackage

// File: rtl/lrr_zone_decode.sv
module lrr_zone_decode
    import lrr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_ATTR = 7,
    localparam int IDX_W   = $clog2(NUM_ATTR)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_vga,
    output logic              in_attr,
    output logic [IDX_W-1:0]  attr_idx,
    output logic              attr_hi,
    output logic              in_low_hole,
    output logic              in_high_hole
);
    logic below_1m;
    logic below_16m;
    logic [3:0] seg;

    assign below_1m  = (addr[ADDR_W-1:MEG_SHIFT] == '0);
    assign below_16m = (addr[ADDR_W-1:HI_SHIFT] == '0);
    assign seg       = addr[MEG_SHIFT-3:SEG_SHIFT];

    always_comb begin
        in_vga       = below_1m && (addr[MEG_SHIFT-1:MEG_SHIFT-3] == 3'b101);
        in_low_hole  = below_1m && (addr[MEG_SHIFT-1:MEG_SHIFT-3] == 3'b100);
        in_high_hole = below_16m && (addr[HI_SHIFT-1:MEG_SHIFT] == 4'hF);
        in_attr      = below_1m && (addr[MEG_SHIFT-1:MEG_SHIFT-2] == 2'b11);
        attr_idx     = '0;
        attr_hi      = 1'b0;
        if (in_attr) begin
            if (seg[3:2] == 2'b11) begin
                attr_idx = '0;            // top 64 KB block
                attr_hi  = 1'b1;
            end else begin
                attr_idx = IDX_W'(seg[3:1]) + IDX_W'(1);
                attr_hi  = seg[0];
            end
        end
    end
endmodule

// File: rtl/lrr_attr_pick.sv
module lrr_attr_pick
    import lrr_pkg::*;
#(
    parameter int NUM_ATTR = 7,
    parameter int ATTR_W   = 8,
    localparam int IDX_W   = $clog2(NUM_ATTR)
) (
    input  logic [NUM_ATTR*ATTR_W-1:0] attr_cfg,
    input  logic [IDX_W-1:0]           attr_idx,
    input  logic                       attr_hi,
    input  logic                       is_write,
    output logic                       allow_dram
);
    logic [FIELD_W-1:0] lo_f [NUM_ATTR];
    logic [FIELD_W-1:0] hi_f [NUM_ATTR];
    logic [FIELD_W-1:0] pol;

    for (genvar k = 0; k < NUM_ATTR; k++) begin : g_byte
        assign lo_f[k] = attr_cfg[k*ATTR_W +: FIELD_W];
        assign hi_f[k] = attr_cfg[k*ATTR_W + HI_FIELD_L +: FIELD_W];
    end

    always_comb begin
        pol = '0;
        for (int k = 0; k < NUM_ATTR; k++) begin
            if (attr_idx == IDX_W'(k)) pol = attr_hi ? hi_f[k] : lo_f[k];
        end
        allow_dram = is_write ? pol[1] : pol[0];
    end
endmodule

// File: rtl/lrr_hole_check.sv
module lrr_hole_check
    import lrr_pkg::*;
(
    input  logic [1:0] hole_sel,
    input  logic       in_low_hole,
    input  logic       in_high_hole,
    output logic       force_io
);
    always_comb begin
        unique case (hole_code_e'(hole_sel))
            HOLE_LOW:  force_io = in_low_hole;
            HOLE_HIGH: force_io = in_high_hole;
            HOLE_NONE,
            HOLE_RSVD: force_io = 1'b0;
            default:   force_io = 1'b0;
        endcase
    end
endmodule

// File: rtl/legacy_route_top.sv
module legacy_route_top
    import lrr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_ATTR = 7,
    parameter int ATTR_W   = 8,
    localparam int IDX_W   = $clog2(NUM_ATTR),
    localparam int CFG_W   = NUM_ATTR * ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CFG_W-1:0]  attr_cfg,
    input  logic [1:0]        hole_sel,
    output logic              to_dram,
    output logic              to_mmio
);
    logic             in_vga, in_attr, attr_hi, in_low_hole, in_high_hole;
    logic [IDX_W-1:0] attr_idx;
    logic             allow_dram, force_io, go_dram;
    route_state_e     state_q, state_d;

    lrr_zone_decode #(.ADDR_W(ADDR_W), .NUM_ATTR(NUM_ATTR)) zone_i (
        .addr(acc_addr), .in_vga(in_vga), .in_attr(in_attr),
        .attr_idx(attr_idx), .attr_hi(attr_hi),
        .in_low_hole(in_low_hole), .in_high_hole(in_high_hole)
    );

    lrr_attr_pick #(.NUM_ATTR(NUM_ATTR), .ATTR_W(ATTR_W)) pick_i (
        .attr_cfg(attr_cfg), .attr_idx(attr_idx), .attr_hi(attr_hi),
        .is_write(acc_write), .allow_dram(allow_dram)
    );

    lrr_hole_check hole_i (
        .hole_sel(hole_sel), .in_low_hole(in_low_hole),
        .in_high_hole(in_high_hole), .force_io(force_io)
    );

    always_comb begin
        if (in_vga)       go_dram = 1'b0;
        else if (in_attr) go_dram = allow_dram;
        else              go_dram = !force_io;
    end

    always_comb begin
        unique case (state_q)
            RT_IDLE, RT_DRAM, RT_MMIO: begin
                if (!acc_valid)   state_d = RT_IDLE;
                else if (go_dram) state_d = RT_DRAM;
                else              state_d = RT_MMIO;
            end
            default: state_d = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        to_dram = 1'b0;
        to_mmio = 1'b0;
        unique case (state_q)
            RT_DRAM: to_dram = 1'b1;
            RT_MMIO: to_mmio = 1'b1;
            RT_IDLE: ;
            default: ;
        endcase
    end

    // R2
    one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ($countones({to_dram, to_mmio}) == 1));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!to_dram && !to_mmio));
    // R5
    vga_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= ADDR_W'(32'h000A_0000) && acc_addr < ADDR_W'(32'h000C_0000))
        |=> to_mmio);
    // R6
    low_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hole_sel == 2'b01 && acc_addr >= ADDR_W'(32'h0008_0000)
         && acc_addr < ADDR_W'(32'h000A_0000)) |=> to_mmio);
    // R8
    no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (hole_sel == 2'b00 || hole_sel == 2'b11)
         && acc_addr >= ADDR_W'(32'h00F0_0000) && acc_addr < ADDR_W'(32'h0100_0000)) |=> to_dram);
    // R9
    far_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= ADDR_W'(32'h0100_0000)) |=> to_dram);
endmodule

// File: tb/legacy_route_top_tb_top.sv
`timescale 1ns/1ps
module legacy_route_top_tb_top;
    localparam int ADDR_W = 32;
    localparam int CFG_W  = 56;

    typedef struct {
        logic [1:0] exp;   // {dram, mmio}
        int         req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [CFG_W-1:0]  attr_cfg = '0;
    logic [1:0]        hole_sel = 2'b00;
    logic              to_dram, to_mmio;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    legacy_route_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .attr_cfg(attr_cfg), .hole_sel(hole_sel),
        .to_dram(to_dram), .to_mmio(to_mmio)
    );

    // Reference model built from the requirements: returns {dram, mmio}, tag.
    function automatic void model(input logic [31:0] a, input logic wr,
                                  input logic [CFG_W-1:0] cfg, input logic [1:0] hs,
                                  output logic [1:0] e, output int tag);
        logic [1:0] pol;
        int seg;
        int r;
        if (a >= 32'hA0000 && a < 32'hC0000) begin
            e = 2'b01; tag = 5;                                   // R5
        end else if (a >= 32'hC0000 && a < 32'hF0000) begin
            seg = int'((a - 32'hC0000) >> 14);                   // R3
            r   = 1 + seg / 2;
            pol = cfg[r*8 + ((seg % 2) ? 4 : 0) +: 2];
            e   = (wr ? pol[1] : pol[0]) ? 2'b10 : 2'b01; tag = 3;
        end else if (a >= 32'hF0000 && a < 32'h100000) begin
            pol = cfg[5:4];                                       // R4
            e   = (wr ? pol[1] : pol[0]) ? 2'b10 : 2'b01; tag = 4;
        end else if (a >= 32'h80000 && a < 32'hA0000) begin
            e = (hs == 2'b01) ? 2'b01 : 2'b10; tag = (hs == 2'b01) ? 6 : 8; // R6 / R8
        end else if (a >= 32'hF00000 && a < 32'h1000000) begin
            e = (hs == 2'b10) ? 2'b01 : 2'b10; tag = (hs == 2'b10) ? 7 : 8; // R7 / R8
        end else begin
            e = 2'b10; tag = 9;                                   // R9
        end
    endfunction

    task automatic send(input logic [31:0] a, input logic wr);
        item_t it;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        model(a, wr, attr_cfg, hole_sel, it.exp, it.req);
        sb_q.push_back(it);
    endtask

    task automatic idle();
        item_t it;
        @(negedge clk);
        acc_valid = 1'b0;
        it.exp = 2'b00; it.req = 2;                               // R2
        sb_q.push_back(it);
    endtask

    task automatic set_cfg(input logic [CFG_W-1:0] c, input logic [1:0] hs);
        item_t it;
        @(negedge clk);
        acc_valid = 1'b0; attr_cfg = c; hole_sel = hs;
        it.exp = 2'b00; it.req = 2;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one result per clock, just after the edge.
    always begin
        item_t it;
        @(posedge clk);
        #1;
        if (rst_n && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_tests++;
            if ({to_dram, to_mmio} !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d: {to_dram,to_mmio} actual=%b expected=%b",
                         it.req, {to_dram, to_mmio}, it.exp);
            end
        end
    end

    function automatic logic [CFG_W-1:0] pattern(input int p);
        logic [CFG_W-1:0] c = '0;
        for (int k = 0; k < 7; k++) begin
            c[k*8 +: 2]     = 2'((k + p) % 4);
            c[k*8 + 4 +: 2] = 2'((k + p + 2) % 4);
            if (p % 2 == 1) begin        // R4: unused bits toggled
                c[k*8 + 2 +: 2] = 2'b11;
                c[k*8 + 6 +: 2] = 2'b11;
            end
        end
        return c;
    endfunction

    initial begin
        // R1: outputs low during reset and right after
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if ({to_dram, to_mmio} !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: during reset actual=%b expected=00", {to_dram, to_mmio});
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        n_tests++;
        if ({to_dram, to_mmio} !== 2'b00) begin
            n_fail++;
            $display("FAIL R1: after reset actual=%b expected=00", {to_dram, to_mmio});
        end

        // R3 / R4: every segment, both directions, four policy patterns
        for (int p = 0; p < 4; p++) begin
            set_cfg(pattern(p), 2'b00);
            for (int s = 0; s < 12; s++) begin
                send(32'hC0000 + 32'(s) * 32'h4000, 1'b0);
                send(32'hC0000 + 32'(s) * 32'h4000 + 32'h3FFC, 1'b1);
            end
            send(32'hF0000, 1'b0);
            send(32'hFFFFF, 1'b1);
            idle();                                   // R2
        end

        // R5: display window under all-DRAM policy and every hole code
        set_cfg({CFG_W{1'b1}}, 2'b01);
        for (int h = 0; h < 4; h++) begin
            set_cfg({CFG_W{1'b1}}, 2'(h));
            send(32'hA0000, 1'b0);
            send(32'hBFFFF, 1'b1);
            // R6 / R7 / R8: hole edges and neighbours
            send(32'h7FFFF, 1'b0);
            send(32'h80000, 1'b0);
            send(32'h9FFFF, 1'b1);
            send(32'hEFFFFF, 1'b1);
            send(32'hF00000, 1'b0);
            send(32'hFFFFFF, 1'b1);
            // R9: plain memory and aliases above 16 MB
            send(32'h1000000, 1'b1);
            send(32'h10C0000, 1'b0);
            send(32'h10A0000, 1'b1);
            send(32'h1F00000, 1'b0);
            send(32'h0000_0000, 1'b1);
            send(32'h0010_0000, 1'b0);
        end

        // R2: back-to-back with idle gaps
        set_cfg('0, 2'b00);
        send(32'hC4000, 1'b0);
        idle();
        send(32'h400000, 1'b1);
        idle();
        idle();

        wait (sb_q.size() == 0);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule